// File: doc/BRIEF.md
# Private Interrupt Pending Updater

This block turns two kinds of private interrupt events into set-pending pulses for a per-core register bank. Sixteen peripheral input lines (interrupt IDs 16 to 31) are tracked. A line configured as edge-triggered produces a pulse on its rising edge. A line configured as level-triggered never produces a pulse; its state is only reported on a registered level vector, which the bank merges into its pending read-out.

Software-generated interrupt requests (IDs 0 to 15) arrive one per cycle. Each carries a requested group and a non-secure flag. The block takes the interrupt's group and its two-bit non-secure access field from the bank. It then decides whether the request is accepted and, if so, emits a one-hot pulse for that ID. Every output is registered and appears exactly one clock after the input that caused it.

Top module: `pirq_pending_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls (with all inputs idle), `set_pend` and `ppi_level` are zero.
- R2: `ppi_level[i]` equals the value `ppi_in[i]` had at the previous rising clock edge. An input that keeps its value causes no change and no pulse.
- R3: If `ppi_edge[i]` is 1 and `ppi_in[i]` rises from 0 to 1, `set_pend[16+i]` is 1 for exactly one cycle, in the same cycle that `ppi_level[i]` first reads 1. Holding the line high gives no further pulse.
- R4: A line with `ppi_edge[i]` = 0 never drives `set_pend[16+i]`, whatever its input does.
- R5: The configured class of software interrupt n is derived as follows. If `sgi_grp[n]` = 1, the class is non-secure group 1. If `sgi_grp[n]` = 0 and `sgi_mod[n]` = 1, the class is secure group 1. If both are 0, the class is group 0. When `sec_disable` = 1, `sgi_mod` is ignored, so a 0 in `sgi_grp` always means group 0.
- R6: A request coded as secure group 1 (`req_grp` = 1) that targets an interrupt of class group 0 is handled as a group-0 request.
- R7: After the adjustment in R6, a request whose group code (0 = group 0, 1 = secure group 1, 2 = non-secure group 1) differs from the interrupt's class is dropped. Code 3 is always dropped.
- R8: When `req_ns` = 1 and `sec_disable` = 0, the access field `sgi_nsacc[2n+1:2n]` limits acceptance. A group-0 interrupt needs a field of at least 1, and a secure group-1 interrupt needs a field of at least 2; otherwise the request is dropped. Non-secure group-1 interrupts, and all requests made while `sec_disable` = 1, skip this check.
- R9: An accepted request for ID n sets `set_pend[n]` for exactly one cycle, on the cycle after the strobe. No other bit in the range 0 to 15 is set, and a cycle without a strobe gives no pulse in that range.
- R10: A request with `req_id` of 16 or more has no effect on `set_pend`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ppi_in | input | 16 | Peripheral interrupt input lines, bit i is ID 16+i |
| ppi_edge | input | 16 | 1 = line i is edge-triggered |
| sgi_grp | input | 16 | Group bit per software interrupt |
| sgi_mod | input | 16 | Group modifier bit per software interrupt |
| sgi_nsacc | input | 32 | Two-bit non-secure access field per software interrupt |
| sec_disable | input | 1 | 1 = single security state |
| req_valid | input | 1 | Software interrupt request strobe |
| req_id | input | 5 | Requested interrupt ID |
| req_grp | input | 2 | Requested group code |
| req_ns | input | 1 | Request comes from the non-secure state |
| set_pend | output | 32 | One-cycle set-pending pulses, bit = interrupt ID |
| ppi_level | output | 16 | Registered input level per peripheral line |

## Verification
The assertions assume that `ppi_edge` and the group, modifier and access inputs are synchronous and settle before the clock edge. They also assume that a strobe carries a single request, so the pulse in the range 0 to 15 is at most one-hot. The bench drives every input at the falling edge and changes the configuration only every few dozen cycles. This keeps the inputs inside those assumptions while still crossing every class, access value, request code and an out-of-range ID.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int SGI_CNT = 16;
    localparam int PPI_CNT = 16;
    localparam int ID_W    = 5;
    localparam int ACC_W   = 2;

    typedef enum logic [1:0] {
        GRP_SEC0 = 2'd0,
        GRP_SEC1 = 2'd1,
        GRP_NS1  = 2'd2,
        GRP_BAD  = 2'd3
    } grp_e;

    typedef struct packed {
        logic            vld;
        logic [ID_W-1:0] id;
        grp_e            grp;
        logic            ns;
    } sgi_req_t;

    // Class of a software interrupt from its group and modifier bits.
    function automatic grp_e class_of(logic g, logic m, logic sec_off);
        if (g)
            return GRP_NS1;
        else if (m && !sec_off)
            return GRP_SEC1;
        else
            return GRP_SEC0;
    endfunction

    // A secure group-1 request hitting a group-0 interrupt counts as group 0.
    function automatic grp_e fold_req(grp_e req, grp_e cls);
        if (req == GRP_SEC1 && cls == GRP_SEC0)
            return GRP_SEC0;
        return req;
    endfunction

    // Access-field gate for a non-secure request when security is on.
    function automatic logic ns_permits(grp_e cls, logic [ACC_W-1:0] acc);
        case (cls)
            GRP_SEC0: return acc >= 2'd1;
            GRP_SEC1: return acc >= 2'd2;
            default:  return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/pirq_line_tracker.sv
module pirq_line_tracker #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] line_in,
    input  logic [N-1:0] edge_cfg,
    output logic [N-1:0] lvl_q,
    output logic [N-1:0] rise_q
);

    for (genvar i = 0; i < N; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                lvl_q[i]  <= 1'b0;
                rise_q[i] <= 1'b0;
            end else begin
                lvl_q[i]  <= line_in[i];
                rise_q[i] <= line_in[i] & ~lvl_q[i] & edge_cfg[i];
            end
        end
    end

    AST_RISE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        (rise_q & ~(lvl_q & ~$past(lvl_q))) == '0); // R3

    AST_LEVEL_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        (rise_q & ~$past(edge_cfg)) == '0); // R4

endmodule

// File: rtl/pirq_sgi_gate.sv
module pirq_sgi_gate
    import pirq_pkg::*;
#(
    parameter int N     = SGI_CNT,
    parameter int IDW   = ID_W,
    parameter int AW    = ACC_W
) (
    input  logic            clk,
    input  logic            rst,
    input  sgi_req_t        req,
    input  logic [N-1:0]    grp_cfg,
    input  logic [N-1:0]    mod_cfg,
    input  logic [AW*N-1:0] acc_cfg,
    input  logic            sec_off,
    output logic [N-1:0]    pulse_q
);

    localparam int IDX_W = $clog2(N);

    logic [IDX_W-1:0] idx;
    logic             in_range;
    grp_e             cls;
    grp_e             eff;
    logic [AW-1:0]    acc;
    logic             accept;
    logic [N-1:0]     hit;

    always_comb begin
        idx      = req.id[IDX_W-1:0];
        in_range = req.id < IDW'(N);
        cls      = class_of(grp_cfg[idx], mod_cfg[idx], sec_off);
        eff      = fold_req(req.grp, cls);
        acc      = acc_cfg[AW*idx +: AW];
        accept   = req.vld && in_range && (req.grp != GRP_BAD) && (eff == cls)
                   && (!req.ns || sec_off || ns_permits(cls, acc));
    end

    for (genvar i = 0; i < N; i++) begin : g_hit
        assign hit[i] = accept && (idx == IDX_W'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) pulse_q <= '0;
        else     pulse_q <= hit;
    end

    AST_ONE_SGI_PULSE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pulse_q)); // R9

    AST_NO_STROBE_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        !$past(req.vld) |-> pulse_q == '0); // R9

    AST_HIGH_ID_IGNORED: assert property (@(posedge clk) disable iff (rst)
        $past(req.vld && req.id >= IDW'(N)) |-> pulse_q == '0); // R10

    AST_NS_G0_ZERO_ACCESS: assert property (@(posedge clk) disable iff (rst)
        $past(req.vld && req.ns && !sec_off && !grp_cfg[idx] && !mod_cfg[idx]
              && acc_cfg[AW*idx +: AW] == '0) |-> pulse_q == '0); // R8

endmodule

// File: rtl/pirq_pending_ctrl.sv
module pirq_pending_ctrl
    import pirq_pkg::*;
#(
    parameter int NUM_SGI = SGI_CNT,
    parameter int NUM_PPI = PPI_CNT,
    parameter int REQ_W   = ID_W,
    parameter int NSACC_W = ACC_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_PPI-1:0]         ppi_in,
    input  logic [NUM_PPI-1:0]         ppi_edge,
    input  logic [NUM_SGI-1:0]         sgi_grp,
    input  logic [NUM_SGI-1:0]         sgi_mod,
    input  logic [NSACC_W*NUM_SGI-1:0] sgi_nsacc,
    input  logic                       sec_disable,
    input  logic                       req_valid,
    input  logic [REQ_W-1:0]           req_id,
    input  logic [1:0]                 req_grp,
    input  logic                       req_ns,
    output logic [NUM_SGI+NUM_PPI-1:0] set_pend,
    output logic [NUM_PPI-1:0]         ppi_level
);

    sgi_req_t           req;
    logic [NUM_SGI-1:0] sgi_pulse;
    logic [NUM_PPI-1:0] ppi_pulse;

    always_comb begin
        req.vld = req_valid;
        req.id  = req_id;
        req.grp = grp_e'(req_grp);
        req.ns  = req_ns;
    end

    pirq_line_tracker #(.N(NUM_PPI)) u_lines (
        .clk      (clk),
        .rst      (rst),
        .line_in  (ppi_in),
        .edge_cfg (ppi_edge),
        .lvl_q    (ppi_level),
        .rise_q   (ppi_pulse)
    );

    pirq_sgi_gate #(.N(NUM_SGI), .IDW(REQ_W), .AW(NSACC_W)) u_sgi (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .grp_cfg (sgi_grp),
        .mod_cfg (sgi_mod),
        .acc_cfg (sgi_nsacc),
        .sec_off (sec_disable),
        .pulse_q (sgi_pulse)
    );

    assign set_pend = {ppi_pulse, sgi_pulse};

    AST_LEVEL_TRACKS_INPUT: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ppi_level == $past(ppi_in)); // R2

endmodule

// File: tb/pirq_pending_ctrl_bench.sv
module pirq_pending_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ppi_in = '0;
    logic [15:0] ppi_edge = '0;
    logic [15:0] sgi_grp = '0;
    logic [15:0] sgi_mod = '0;
    logic [31:0] sgi_nsacc = '0;
    logic        sec_disable = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_id = '0;
    logic [1:0]  req_grp = '0;
    logic        req_ns = 1'b0;
    logic [31:0] set_pend;
    logic [15:0] ppi_level;

    int checks = 0;
    int failures = 0;
    logic [15:0] m_lvl = '0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pirq_pending_ctrl u_pirq_pending_ctrl (
        .clk(clk), .rst(rst), .ppi_in(ppi_in), .ppi_edge(ppi_edge),
        .sgi_grp(sgi_grp), .sgi_mod(sgi_mod), .sgi_nsacc(sgi_nsacc),
        .sec_disable(sec_disable), .req_valid(req_valid), .req_id(req_id),
        .req_grp(req_grp), .req_ns(req_ns), .set_pend(set_pend),
        .ppi_level(ppi_level)
    );

    // Expected acceptance from the requirements (R5..R8, R10).
    function automatic bit sgi_ok(logic [4:0] id, logic [1:0] rg, logic ns);
        int cls;
        int eff;
        int acc;
        if (id >= 5'd16) return 0;
        if (rg == 2'd3) return 0;
        if (sgi_grp[id[3:0]]) cls = 2;
        else if (sgi_mod[id[3:0]] && !sec_disable) cls = 1;
        else cls = 0;
        eff = (rg == 2'd1 && cls == 0) ? 0 : int'(rg);
        if (eff != cls) return 0;
        acc = int'(sgi_nsacc[2*id[3:0] +: 2]);
        if (ns && !sec_disable) begin
            if (cls == 0 && acc < 1) return 0;
            if (cls == 1 && acc < 2) return 0;
        end
        return 1;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic step(input string tag);
        logic [31:0] exp_p;
        exp_p = '0;
        exp_p[31:16] = ppi_in & ~m_lvl & ppi_edge;
        if (req_valid && sgi_ok(req_id, req_grp, req_ns)) exp_p[req_id[3:0]] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(tag, set_pend, exp_p);
        check("R2 level", {16'b0, ppi_level}, {16'b0, ppi_in});
        m_lvl = ppi_in;
    endtask

    task automatic sgi(input logic [4:0] id, input logic [1:0] g, input logic ns, input string tag);
        req_valid = 1'b1; req_id = id; req_grp = g; req_ns = ns;
        step(tag);
        req_valid = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check("R1 reset pend", set_pend, '0);
        check("R1 reset level", {16'b0, ppi_level}, '0);
        rst = 1'b0;
        step("R1 after reset");

        // R3 / R4 directed
        ppi_edge = 16'hFFFD;
        ppi_in = 16'h0001; step("R3 rise pulse");
        step("R3 held high no pulse");
        ppi_in = 16'h0002; step("R4 level line no pulse");
        ppi_in = 16'h0003; step("R3 R4 mixed");
        ppi_in = 16'h0000; step("R2 fall");

        // SGI directed
        sgi_grp = 16'h00F0; sgi_mod = 16'h0F00; sgi_nsacc = '0;
        sgi(5'd5, 2'd0, 1'b0, "R5 G1NS class rejects G0");
        sgi(5'd5, 2'd2, 1'b0, "R5 G1NS accepted");
        sgi(5'd1, 2'd1, 1'b0, "R6 secure G1 folded to G0");
        sgi(5'd9, 2'd1, 1'b0, "R5 secure G1 accepted");
        sgi(5'd1, 2'd2, 1'b0, "R7 group mismatch");
        sgi(5'd1, 2'd3, 1'b0, "R7 code 3 dropped");
        step("R9 no strobe no pulse");
        sgi(5'd2, 2'd0, 1'b1, "R8 NS G0 access 0 dropped");
        sgi_nsacc[5:4] = 2'd1;
        sgi(5'd2, 2'd0, 1'b1, "R8 NS G0 access 1 accepted");
        sgi_nsacc[19:18] = 2'd1;
        sgi(5'd9, 2'd1, 1'b1, "R8 NS secure G1 access 1 dropped");
        sgi_nsacc[19:18] = 2'd2;
        sgi(5'd9, 2'd1, 1'b1, "R8 NS secure G1 access 2 accepted");
        sgi(5'd15, 2'd0, 1'b1, "R8 NS G0 access 0 top id");
        sec_disable = 1'b1;
        sgi(5'd9, 2'd0, 1'b0, "R5 modifier ignored when single security");
        sgi(5'd10, 2'd0, 1'b1, "R8 no access check when single security");
        sgi(5'd16, 2'd0, 1'b0, "R10 id 16 ignored");
        sgi(5'd31, 2'd2, 1'b0, "R10 id 31 ignored");
        sec_disable = 1'b0;

        // Random phase
        for (int n = 0; n < 600; n++) begin
            if (n % 40 == 0) begin
                ppi_edge = 16'($urandom); sgi_grp = 16'($urandom);
                sgi_mod = 16'($urandom); sgi_nsacc = $urandom;
                sec_disable = ($urandom_range(3) == 0);
            end
            ppi_in = ppi_in ^ 16'($urandom & $urandom);
            req_valid = $urandom_range(1);
            req_id = 5'($urandom_range(19));
            req_grp = 2'($urandom);
            req_ns = $urandom_range(1);
            step("R3 R4 R6 R7 R8 R9 random");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule